// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers edge-triggered interrupt sources laid out as `NSETS` groups of 32 bits. Each source passes through a two-flop synchronizer and a rising-edge detector; a detected edge latches a sticky pending bit that stays set until software clears it by writing a one to the same bit position in that group's clear register.

A fixed hardwired map assigns a handful of sources a priority level between 1 and 15. These form the high tier. A level is a single pending group, so two sources at the same level are not told apart. The high output carries a 4-bit vector naming the highest level that is both pending and unmasked by the 16-bit per-level mask. Every source outside the map belongs to the low tier. Each low-tier bit has its own enable, and the low output is raised when any enabled low-tier bit is pending. A global enable gates both outputs, but it never stops capture. The processor services the high line ahead of the low line.

All registers sit on a simple single-cycle register bus. Writes take effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `irq_tier_ctrl`

## Requirements
- R1: A rising edge on a source input sets its pending bit on the third rising clock edge after the input rises. A pulse held for one clock, or a level held for many clocks, produces exactly one pending event.
- R2: A pending bit stays set until it is cleared by software or by reset, whatever the source input does afterward.
- R3: A write to a group's clear register clears each pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. Writing back the value read from status clears all of them. If a new edge lands in the same cycle as a clear of that bit, the bit stays pending.
- R4: The fixed map is as follows; every other source has level 0 and is low tier.
  - Group 3, bits 25 and 24: level 15.
  - Group 3, bit 30: level 14.
  - Group 3, bit 29: level 13.
  - Group 1, bit 18: level 4.
  - Group 1, bit 17: level 3.
  - Group 1, bit 27: level 2.
  - Group 3, bits 7 and 0: level 1.
- R5: `irq_vec_o` equals the highest level L in 1..15 that has any pending source and mask bit L set, and 0 when there is none. Sources that share a level count as one group.
- R6: `irq_high_o` is 1 exactly when the global enable is set and `irq_vec_o` is nonzero. A level whose mask bit is 0 never raises it.
- R7: `irq_low_o` is 1 exactly when the global enable is set and some low-tier source is both pending and enabled. High-tier sources never affect it, whatever their enable bits are.
- R8: With the global enable at 0, both outputs are 0 while edges still latch pending bits. Those bits show up on the outputs once the enable is set again.
- R9: The word address is {group, sub}, with sub in bits 1:0.
  - For group g below NSETS: sub 0 is status (read only), sub 1 is enable (read/write) and sub 2 is clear (write only, reads 0).
  - Address 4*NSETS is control: the per-level mask in bits 15:0 and the global enable in bit 16.
  - Address 4*NSETS+1 is a read-only summary: the vector in bits 3:0, HIGH in bit 4 and LOW in bit 5.
- R10: Asserting reset clears every pending, enable, mask and global-enable bit, so both outputs and the vector read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSETS*32 | Source inputs, group g on bits 32*g+31..32*g |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_high_o | output | 1 | High-tier interrupt line |
| irq_low_o | output | 1 | Low-tier interrupt line |
| irq_vec_o | output | 4 | Highest pending unmasked level |

## Verification
A source edge becomes visible on status, the outputs and the summary three rising edges after the input rises. The bench therefore drives each pulse at a falling edge and waits four more falling edges before it compares anything. Register writes take effect at the rising edge inside the one-cycle strobe, and the outputs follow combinationally, so those checks sample at the falling edge right after the strobe drops. The same-cycle clear and edge collision is placed deliberately: the clear strobe is aimed at the third rising edge after the pulse.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;
  localparam int GRP_W  = 32;
  localparam int LVL_N  = 16;
  localparam int VEC_W  = 4;

  // fixed high-tier map (R4)
  function automatic logic [VEC_W-1:0] src_level(input int grp, input int bit_i);
    logic [VEC_W-1:0] lvl;
    lvl = '0;
    if (grp == 3) begin
      if (bit_i == 25 || bit_i == 24) lvl = 4'd15;
      else if (bit_i == 30)           lvl = 4'd14;
      else if (bit_i == 29)           lvl = 4'd13;
      else if (bit_i == 7 || bit_i == 0) lvl = 4'd1;
    end else if (grp == 1) begin
      if (bit_i == 18)      lvl = 4'd4;
      else if (bit_i == 17) lvl = 4'd3;
      else if (bit_i == 27) lvl = 4'd2;
    end
    return lvl;
  endfunction

  function automatic logic [GRP_W-1:0] level_bits(input int grp, input int lvl);
    logic [GRP_W-1:0] m;
    m = '0;
    for (int b = 0; b < GRP_W; b++)
      if (int'(src_level(grp, b)) == lvl) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [GRP_W-1:0] high_bits(input int grp);
    logic [GRP_W-1:0] m;
    m = '0;
    for (int b = 0; b < GRP_W; b++)
      if (src_level(grp, b) != '0) m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign edge_o = s2_q & ~prev_q;

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_o & $past(edge_o)) == '0)); // R1
endmodule

// File: rtl/irq_pend_set.sv
module irq_pend_set #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q, pend_d;
  logic         upd;

  always_comb begin
    upd    = (|edge_i) | (|clr_i);
    pend_d = (pend_q & ~clr_i) | edge_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(clr_i) & ~$past(edge_i)) & pend_q) == '0)); // R3
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_tier_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] lvl_i,
  input  logic [LVL_N-1:0] msk_i,
  output logic [VEC_W-1:0] vec_o
);
  logic [LVL_N-1:0] act;

  always_comb begin
    act   = lvl_i & msk_i;
    vec_o = '0;
    for (int l = 1; l < LVL_N; l++)
      if (act[l]) vec_o = VEC_W'(l);
  end

  AST_VEC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> (lvl_i[vec_o] && msk_i[vec_o])); // R5
  AST_VEC_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (((lvl_i[LVL_N-1:1] & msk_i[LVL_N-1:1]) >> vec_o) == '0)); // R5
endmodule

// File: rtl/irq_tier_ctrl.sv
module irq_tier_ctrl
  import irq_tier_pkg::*;
#(
  parameter int NSETS = 4,
  parameter int AW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSETS*GRP_W-1:0] src_i,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  output logic                   irq_high_o,
  output logic                   irq_low_o,
  output logic [VEC_W-1:0]       irq_vec_o
);
  localparam int IW  = AW - 2;
  localparam int SIW = (NSETS > 1) ? $clog2(NSETS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs_n  <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs_n  <= rs1_q;
    end
  end

  logic [IW-1:0] a_idx;
  logic [1:0]    a_sub;
  assign a_idx = bus_addr[AW-1:2];
  assign a_sub = bus_addr[1:0];

  logic [NSETS-1:0][GRP_W-1:0] pend_all, en_q, en_d, clr_all, low_vec;
  logic [NSETS-1:0]            en_we;
  logic [LVL_N-1:0]            mask_q, mask_d;
  logic                        gen_q, gen_d, ctrl_we;

  // per-group capture and pending
  for (genvar g = 0; g < NSETS; g++) begin : g_grp
    localparam logic [GRP_W-1:0] HI = high_bits(g);
    logic [GRP_W-1:0] edg;

    irq_sync_edge #(.W(GRP_W)) u_edge (
      .clk(clk), .rst_n(rs_n),
      .raw_i(src_i[g*GRP_W +: GRP_W]), .edge_o(edg));

    assign clr_all[g] = (bus_wr && a_idx == IW'(g) && a_sub == 2'd2) ? bus_wdata : '0;

    irq_pend_set #(.W(GRP_W)) u_pend (
      .clk(clk), .rst_n(rs_n),
      .edge_i(edg), .clr_i(clr_all[g]), .pend_o(pend_all[g]));

    assign en_we[g]   = bus_wr && a_idx == IW'(g) && a_sub == 2'd1;
    assign en_d[g]    = bus_wdata;
    assign low_vec[g] = pend_all[g] & en_q[g] & ~HI;
  end

  // per-level pending groups
  logic [LVL_N-1:0][NSETS-1:0] lvl_hit;
  logic [LVL_N-1:0]            lvl_pend;
  assign lvl_hit[0] = '0;
  for (genvar l = 1; l < LVL_N; l++) begin : g_lvl
    for (genvar g = 0; g < NSETS; g++) begin : g_src
      localparam logic [GRP_W-1:0] LM = level_bits(g, l);
      assign lvl_hit[l][g] = |(pend_all[g] & LM);
    end
  end
  for (genvar l = 0; l < LVL_N; l++) begin : g_or
    assign lvl_pend[l] = |lvl_hit[l];
  end

  // control register next state
  always_comb begin
    ctrl_we = bus_wr && int'(a_idx) == NSETS && a_sub == 2'd0;
    mask_d  = bus_wdata[LVL_N-1:0];
    gen_d   = bus_wdata[16];
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
    end else if (ctrl_we) begin
      mask_q <= mask_d;
      gen_q  <= gen_d;
    end
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_en
    always_ff @(posedge clk or negedge rs_n) begin
      if (!rs_n)          en_q[g] <= '0;
      else if (en_we[g])  en_q[g] <= en_d[g];
    end
  end

  logic [VEC_W-1:0] vec;
  irq_level_enc u_enc (
    .clk(clk), .rst_n(rs_n),
    .lvl_i(lvl_pend), .msk_i(mask_q), .vec_o(vec));

  assign irq_vec_o  = vec;
  assign irq_high_o = gen_q && (vec != '0);
  assign irq_low_o  = gen_q && (|low_vec);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (int'(a_idx) < NSETS) begin
      case (a_sub)
        2'd0:    bus_rdata = pend_all[a_idx[SIW-1:0]];
        2'd1:    bus_rdata = en_q[a_idx[SIW-1:0]];
        default: bus_rdata = '0;
      endcase
    end else if (int'(a_idx) == NSETS) begin
      case (a_sub)
        2'd0:    bus_rdata = {15'd0, gen_q, mask_q};
        2'd1:    bus_rdata = {26'd0, irq_low_o, irq_high_o, vec};
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_HIGH_MASKED: assert property (@(posedge clk) disable iff (!rs_n)
    irq_high_o |-> (mask_q[irq_vec_o] && gen_q)); // R6
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(gen_q) |-> (!irq_high_o && !irq_low_o)); // R8
endmodule

// File: tb/tb_irq_tier_ctrl.sv
module tb_irq_tier_ctrl;
  localparam int NS = 4;
  localparam int AWB = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NS*32-1:0] src = '0;
  logic          bus_wr = 0;
  logic [AWB-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_high, irq_low;
  logic [3:0]    irq_vec;

  irq_tier_ctrl #(.NSETS(NS), .AW(AWB)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_high_o(irq_high), .irq_low_o(irq_low), .irq_vec_o(irq_vec));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_pend [NS];
  logic [31:0] m_en   [NS];
  logic [15:0] m_mask;
  logic        m_gen;

  function automatic int blevel(int s, int b);
    if (s == 3 && (b == 25 || b == 24)) return 15;
    if (s == 3 && b == 30) return 14;
    if (s == 3 && b == 29) return 13;
    if (s == 1 && b == 18) return 4;
    if (s == 1 && b == 17) return 3;
    if (s == 1 && b == 27) return 2;
    if (s == 3 && (b == 7 || b == 0)) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] exp_vec();
    for (int l = 15; l >= 1; l--)
      if (m_mask[l])
        for (int s = 0; s < NS; s++)
          for (int b = 0; b < 32; b++)
            if (m_pend[s][b] && blevel(s, b) == l) return 4'(l);
    return 4'd0;
  endfunction

  function automatic logic exp_low();
    if (!m_gen) return 1'b0;
    for (int s = 0; s < NS; s++)
      for (int b = 0; b < 32; b++)
        if (m_pend[s][b] && m_en[s][b] && blevel(s, b) == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [AWB-1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(logic [AWB-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic wr_en(int s, logic [31:0] d);
    wr(AWB'(4*s+1), d); m_en[s] = d;
  endtask
  task automatic wr_clr(int s, logic [31:0] d);
    wr(AWB'(4*s+2), d); m_pend[s] &= ~d;
  endtask
  task automatic wr_ctrl(logic [15:0] msk, logic g);
    wr(AWB'(4*NS), {15'd0, g, msk}); m_mask = msk; m_gen = g;
  endtask

  task automatic pulse(int s, logic [31:0] bits, int hold);
    @(negedge clk);
    src[s*32 +: 32] = bits;
    repeat (hold) @(negedge clk);
    src[s*32 +: 32] = '0;
    repeat (4) @(negedge clk);
    m_pend[s] |= bits;
  endtask

  task automatic check_all(string tag);
    logic [31:0] v;
    logic [3:0]  ev;
    logic        eh, el;
    ev = exp_vec();
    eh = m_gen && ev != 0;
    el = exp_low();
    chk({tag, " R5 vector"}, 32'(irq_vec), 32'(ev));
    chk({tag, " R6 high"}, 32'(irq_high), 32'(eh));
    chk({tag, " R7 low"}, 32'(irq_low), 32'(el));
    rd(AWB'(4*NS+1), v);
    chk({tag, " R9 summary"}, v, {26'd0, el, eh, ev});
    rd(AWB'(4*NS), v);
    chk({tag, " R9 control"}, v, {15'd0, m_gen, m_mask});
    for (int s = 0; s < NS; s++) begin
      rd(AWB'(4*s), v);
      chk({tag, " R2 status"}, v, m_pend[s]);
      rd(AWB'(4*s+1), v);
      chk({tag, " R9 enable"}, v, m_en[s]);
      rd(AWB'(4*s+2), v);
      chk({tag, " R9 clear reads 0"}, v, 32'd0);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin m_pend[s] = '0; m_en[s] = '0; end
    m_mask = '0; m_gen = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R10 reset state");

    // R1: one-clock pulse, single event; held level, single event
    wr_ctrl(16'hFFFF, 1);
    wr_en(0, 32'hFFFF_FFFF);
    pulse(0, 32'h0000_0010, 1);
    check_all("R1 pulse");
    wr_clr(0, 32'h0000_0010);
    pulse(0, 32'h0000_0020, 12);
    check_all("R1 held");
    wr_clr(0, 32'h0000_0020);
    repeat (6) @(negedge clk);
    check_all("R1 no re-trigger");

    // R3: zero write leaves bits, write-back of status clears all
    pulse(2, 32'hA5A5_0001, 1);
    wr_clr(2, 32'h0);
    check_all("R3 zero clear");
    rd(AWB'(4*2), v);
    wr_clr(2, v);
    check_all("R3 write back");

    // R3: clear and new edge in the same cycle -> stays pending
    pulse(2, 32'h0000_0100, 1);
    @(negedge clk); src[2*32+8] = 1'b1;
    @(negedge clk); src[2*32+8] = 1'b0;
    @(negedge clk); bus_wr = 1; bus_addr = AWB'(4*2+2); bus_wdata = 32'h100;
    @(negedge clk); bus_wr = 0;
    rd(AWB'(4*2), v);
    chk("R3 edge beats clear", v, 32'h100);
    wr_clr(2, 32'h100);

    // R4/R5: ties and masking
    pulse(3, 32'h0300_0000, 1);
    check_all("R4 level15 tie");
    chk("R5 tie vector 15", 32'(irq_vec), 32'd15);
    pulse(3, 32'h4000_0000, 1);
    wr_ctrl(16'h7FFF, 1);
    check_all("R6 mask 15 off");
    chk("R6 vector falls to 14", 32'(irq_vec), 32'd14);
    wr_ctrl(16'h0000, 1);
    check_all("R6 all masked");
    chk("R6 high off when masked", 32'(irq_high), 32'd0);

    // R7: high-tier source enabled does not drive low
    wr_clr(3, 32'hFFFF_FFFF);
    wr_en(1, 32'h0806_0000);
    pulse(1, 32'h0806_0000, 1);
    check_all("R7 high bits ignored by low");
    chk("R7 low stays 0", 32'(irq_low), 32'd0);
    wr_ctrl(16'h001C, 1);
    chk("R4 group1 bit18 level 4", 32'(irq_vec), 32'd4);
    wr_clr(1, 32'hFFFF_FFFF);

    // R8: global enable off, capture continues
    wr_ctrl(16'hFFFF, 0);
    pulse(3, 32'h2000_0000, 1);
    pulse(0, 32'h0000_0001, 1);
    check_all("R8 gated");
    chk("R8 high gated", 32'(irq_high), 32'd0);
    wr_ctrl(16'hFFFF, 1);
    check_all("R8 reopened");
    chk("R8 vector 13", 32'(irq_vec), 32'd13);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op, s;
      op = int'($urandom % 6);
      s  = int'($urandom % NS);
      case (op)
        0: pulse(s, $urandom & $urandom & $urandom, 1 + int'($urandom % 3));
        1: wr_en(s, $urandom);
        2: wr_clr(s, ($urandom % 2) ? m_pend[s] : $urandom);
        3: wr_ctrl(16'($urandom), ($urandom % 4) != 0);
        4: pulse(3, 32'h1 << (($urandom % 2) ? 24 + ($urandom % 7) : ($urandom % 8)), 1);
        default: pulse(1, 32'h1 << (17 + ($urandom % 11)), 1);
      endcase
      check_all("random");
    end

    // R10: reset mid-run
    wr_en(0, 32'hFFFF_FFFF);
    pulse(0, 32'h00FF_0000, 1);
    pulse(3, 32'h0100_0000, 1);
    @(negedge clk); rst_n = 0;
    model_reset();
    #1 check_all("R10 reset mid-run");
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R10 after release");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule